// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port that lets a host reach a bank of internal registers of mixed width over a four-wire link: a serial clock, a data input, a data output and an active-low frame select. Each frame opens with a command byte. The top bit of the command byte gives the direction and the low seven bits give a register address. The bytes that follow carry the register contents. How many bytes there are depends on the address, because each address has its own entry in a width table.

The serial pins are brought into the system clock domain through synchronisers. The port acts on edges of the serial clock that it detects in that domain. It samples incoming bits on the falling edge and presents outgoing bits after the rising edge. The demonstration bank has three kinds of register. Three read-only registers carry external measurement values: a 12-bit frequency value, an 8-bit temperature value and a sign-extended waveform sample. Three read/write settings registers are 8, 16 and 12 bits wide. A reserved address window reads as zero and drops writes.

Top module: `serial_reg_port`

## Requirements
- R1: In the command byte, bit 7 set to 1 means write and 0 means read, and bits 6:0 give the address. During a read frame, the data-phase bits on the data input change no register.
- R2: The number of bytes in the data phase depends on the address. Address 0x10 (12-bit frequency) takes 2 bytes, 0x11 (8-bit temperature) takes 1, 0x12 (24-bit waveform) takes 3, 0x13 (8-bit mode) takes 1, 0x45 (16-bit numerator) takes 2 and 0x46 (12-bit denominator) takes 2. Every other address takes 1 byte.
- R3: The data input is sampled on the falling edge of the serial clock. The data output changes only after a rising edge, or after the frame select goes high. Multi-byte values are sent most significant bit first.
- R4: A complete write frame to 0x13, 0x45 or 0x46 updates that register, and a later read returns the value written.
- R5: A 12-bit register is read as two bytes. Its value is right-aligned and the upper four bits are zero. A write keeps only the low 12 bits.
- R6: Writes to the read-only addresses 0x10, 0x11 and 0x12 are discarded, and no register changes.
- R7: Addresses 0x49 to 0x7D inclusive are reserved. Reads from them return zero, and writes to them change no register.
- R8: Address 0x12 returns the 16-bit waveform input sample, sign-extended to 24 bits.
- R9: If the frame select goes high before the last data bit of a write, the frame is aborted and nothing is written.
- R10: The data output is 0 whenever the frame select is high.
- R11: After reset, all read/write registers hold zero and the data output is 0.
- R12: Serial clock edges that arrive after a frame's data phase is complete are ignored until the frame select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| freq_in | input | 12 | Measured line frequency value for address 0x10 |
| temp_in | input | 8 | Measured temperature value for address 0x11 |
| wave_in | input | SAMPLE_W (16) | Waveform sample for address 0x12 |

## Verification
Every serial pin passes through two synchroniser stages and one edge register. The data output therefore takes its new bit on the third system clock edge after the host raises the serial clock. The bench holds each serial-clock phase for eight system clocks and reads the output just before it drives the next falling edge, so each bit is read well after it has settled. A write commits three clocks after its final falling edge, and the bench only checks it in a later read frame. The idle check on the data output starts four clocks after the frame select rises, which covers the synchroniser delay.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int DATA_W = 24;
  localparam int WR_W   = 16;
  localparam int FREQ_W = 12;
  localparam int TEMP_W = 8;
  localparam int MODE_W = 8;
  localparam int NUM_W  = 16;
  localparam int DEN_W  = 12;

  localparam logic [6:0] A_FREQ = 7'h10;
  localparam logic [6:0] A_TEMP = 7'h11;
  localparam logic [6:0] A_WAVE = 7'h12;
  localparam logic [6:0] A_MODE = 7'h13;
  localparam logic [6:0] A_NUM  = 7'h45;
  localparam logic [6:0] A_DEN  = 7'h46;
  localparam logic [6:0] RSV_LO = 7'h49;
  localparam logic [6:0] RSV_HI = 7'h7D;

  typedef enum logic [1:0] {PH_CMD, PH_WR, PH_RD, PH_DONE} phase_t;

  function automatic int reg_bits(input logic [6:0] a);
    case (a)
      A_FREQ: return FREQ_W;
      A_TEMP: return TEMP_W;
      A_WAVE: return DATA_W;
      A_MODE: return MODE_W;
      A_NUM:  return NUM_W;
      A_DEN:  return DEN_W;
      default: return 8;
    endcase
  endfunction

  // bits on the wire: register width rounded up to whole bytes
  function automatic logic [4:0] xfer_bits(input logic [6:0] a);
    return 5'(8 * ((reg_bits(a) + 7) / 8));
  endfunction

  function automatic logic is_reserved(input logic [6:0] a);
    return (a >= RSV_LO) && (a <= RSV_HI);
  endfunction

  function automatic logic is_read_only(input logic [6:0] a);
    return (a == A_FREQ) || (a == A_TEMP) || (a == A_WAVE);
  endfunction
endpackage

// File: rtl/srp_edge_sync.sv
module srp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_hi,
  output logic din_s
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sck_p, csn_p, dat_p;
  logic sck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= '1;
      csn_p    <= '1;
      dat_p    <= '0;
      sck_last <= 1'b1;
    end else begin
      sck_p[0] <= sclk;
      csn_p[0] <= cs_n;
      dat_p[0] <= din;
      sck_last <= sck_p[LAST];
    end
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_p[g] <= 1'b1;
          csn_p[g] <= 1'b1;
          dat_p[g] <= 1'b0;
        end else begin
          sck_p[g] <= sck_p[g-1];
          csn_p[g] <= csn_p[g-1];
          dat_p[g] <= dat_p[g-1];
        end
      end
    end
  endgenerate

  assign sclk_rise = sck_p[LAST] & ~sck_last;
  assign sclk_fall = ~sck_p[LAST] & sck_last;
  assign cs_hi     = csn_p[LAST];
  assign din_s     = dat_p[LAST];

  assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sclk_rise, sclk_fall}));
endmodule

// File: rtl/srp_frame_ctl.sv
module srp_frame_ctl
  import srp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_rise,
  input  logic                sclk_fall,
  input  logic                cs_hi,
  input  logic                din_s,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [6:0]          rd_addr,
  output logic                wr_en,
  output logic [6:0]          wr_addr,
  output logic [WR_W-1:0]     wr_data,
  output logic                dout
);
  phase_t              phase;
  logic [4:0]          cnt;
  logic [4:0]          nbits_q;
  logic [6:0]          addr_q;
  logic [DATA_W-1:0]   shreg;

  // named events for the checks
  logic [7:0]          cmd_now;
  logic [4:0]          nb_now;
  logic                cmd_done;
  logic                last_bit;
  logic [DATA_W-1:0]   shift_in;

  assign shift_in = {shreg[DATA_W-2:0], din_s};
  assign cmd_now  = shift_in[7:0];
  assign rd_addr  = cmd_now[6:0];
  assign nb_now   = xfer_bits(rd_addr);
  assign cmd_done = sclk_fall && phase == PH_CMD && cnt == 5'd7;
  assign last_bit = sclk_fall && (phase == PH_WR || phase == PH_RD) && cnt == nbits_q - 5'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      nbits_q <= '0;
      addr_q  <= '0;
      shreg   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      dout    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cs_hi) begin
        phase <= PH_CMD;
        cnt   <= '0;
        dout  <= 1'b0;
      end else if (sclk_fall) begin
        case (phase)
          PH_CMD: begin
            cnt   <= cnt + 5'd1;
            shreg <= shift_in;
            if (cmd_done) begin
              cnt     <= '0;
              addr_q  <= rd_addr;
              nbits_q <= nb_now;
              if (cmd_now[7]) begin
                phase <= PH_WR;
              end else begin
                phase <= PH_RD;
                shreg <= rd_data << (DATA_W - int'(nb_now));
              end
            end
          end
          PH_WR: begin
            cnt   <= cnt + 5'd1;
            shreg <= shift_in;
            if (last_bit) begin
              wr_en   <= 1'b1;
              wr_addr <= addr_q;
              wr_data <= shift_in[WR_W-1:0];
              phase   <= PH_DONE;
            end
          end
          PH_RD: begin
            cnt <= cnt + 5'd1;
            if (last_bit) phase <= PH_DONE;
          end
          default: ;
        endcase
      end else if (sclk_rise) begin
        if (phase == PH_RD) begin
          dout  <= shreg[DATA_W-1];
          shreg <= shreg << 1;
        end else begin
          dout <= 1'b0;
        end
      end
    end
  end

  assert_commit_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!cs_hi));
  assert_dout_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !dout);
  assert_dout_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(sclk_rise) || $past(cs_hi)));
  assert_single_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/srp_reg_bank.sv
module srp_reg_bank
  import srp_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [6:0]          wr_addr,
  input  logic [WR_W-1:0]     wr_data,
  input  logic [6:0]          rd_addr,
  input  logic [FREQ_W-1:0]   freq_in,
  input  logic [TEMP_W-1:0]   temp_in,
  input  logic [SAMPLE_W-1:0] wave_in,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int EXT_W = DATA_W - SAMPLE_W;

  logic [MODE_W-1:0] mode_q;
  logic [NUM_W-1:0]  num_q;
  logic [DEN_W-1:0]  den_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      num_q  <= '0;
      den_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE: mode_q <= wr_data[MODE_W-1:0];
        A_NUM:  num_q  <= wr_data[NUM_W-1:0];
        A_DEN:  den_q  <= wr_data[DEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_FREQ:  rd_data = DATA_W'(freq_in);
      A_TEMP:  rd_data = DATA_W'(temp_in);
      A_WAVE:  rd_data = {{EXT_W{wave_in[SAMPLE_W-1]}}, wave_in};
      A_MODE:  rd_data = DATA_W'(mode_q);
      A_NUM:   rd_data = DATA_W'(num_q);
      A_DEN:   rd_data = DATA_W'(den_q);
      default: rd_data = '0;
    endcase
  end

  assert_reserved_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_reserved(wr_addr)) |=> ($stable(mode_q) && $stable(num_q) && $stable(den_q)));
  assert_read_only_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_read_only(wr_addr)) |=> ($stable(mode_q) && $stable(num_q) && $stable(den_q)));
  assert_reserved_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_reserved(rd_addr) |-> (rd_data == '0));
  assert_pad_nibble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_DEN || rd_addr == A_FREQ) |-> (rd_data[DATA_W-1:12] == '0));
  assert_wave_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_WAVE) |-> ($countones(rd_data[DATA_W-1:SAMPLE_W-1]) == 0 ||
                             $countones(rd_data[DATA_W-1:SAMPLE_W-1]) == EXT_W + 1));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                din,
  output logic                dout,
  input  logic [FREQ_W-1:0]   freq_in,
  input  logic [TEMP_W-1:0]   temp_in,
  input  logic [SAMPLE_W-1:0] wave_in
);
  logic              sclk_rise, sclk_fall, cs_hi, din_s;
  logic [6:0]        rd_addr, wr_addr;
  logic              wr_en;
  logic [WR_W-1:0]   wr_data;
  logic [DATA_W-1:0] rd_data;

  srp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_hi(cs_hi), .din_s(din_s)
  );

  srp_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_hi(cs_hi), .din_s(din_s), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout)
  );

  srp_reg_bank #(.SAMPLE_W(SAMPLE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .freq_in(freq_in), .temp_in(temp_in), .wave_in(wave_in),
    .rd_data(rd_data)
  );
endmodule

// File: tb/sim_serial_reg_port.sv
module sim_serial_reg_port;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic dout;
  logic [11:0] freq_in = '0;
  logic [7:0]  temp_in = '0;
  logic [15:0] wave_in = '0;

  int n_cmp = 0, n_bad = 0, idle_cnt = 0;
  int mode_m = 0, num_m = 0, den_m = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_reg_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .freq_in(freq_in), .temp_in(temp_in), .wave_in(wave_in)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %06h expected %06h", req, act, exp);
    end
  endtask

  // R10: every clock with the frame select settled high, the output must be low
  always @(negedge clk) begin
    if (!rst_n || !cs_n) idle_cnt = 0;
    else idle_cnt++;
    if (rst_n && idle_cnt >= 4 && !finished) chk("R10 idle dout", {23'd0, dout}, 24'd0);
  end

  function automatic int wire_bits(input logic [6:0] a);
    case (a)
      7'h10, 7'h45, 7'h46: return 16;
      7'h12: return 24;
      default: return 8;
    endcase
  endfunction

  function automatic logic [23:0] model_read(input logic [6:0] a);
    case (a)
      7'h10: return {12'd0, freq_in};
      7'h11: return {16'd0, temp_in};
      7'h12: return {{8{wave_in[15]}}, wave_in};
      7'h13: return 24'(mode_m);
      7'h45: return 24'(num_m);
      7'h46: return 24'(den_m);
      default: return 24'd0;
    endcase
  endfunction

  task automatic xfer(input logic [7:0] cmd, input logic [23:0] wv, input int nd,
                      output logic [23:0] got);
    got = '0;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      din = cmd[i];
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
      repeat (HP) @(negedge clk);
      sclk = 1'b1;
    end
    for (int i = nd - 1; i >= 0; i--) begin
      din = wv[i];
      repeat (HP) @(negedge clk);
      got = {got[22:0], dout};
      sclk = 1'b0;
      repeat (HP) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    din = 1'b0;
    repeat (3 * HP) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [23:0] v);
    logic [23:0] g;
    xfer({1'b1, a}, v, wire_bits(a), g);
    case (a)
      7'h13: mode_m = int'(v[7:0]);
      7'h45: num_m  = int'(v[15:0]);
      7'h46: den_m  = int'(v[11:0]);
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a);
    logic [23:0] g;
    xfer({1'b0, a}, 24'd0, wire_bits(a), g);
    chk(req, g, model_read(a));
  endtask

  task automatic rw_all(input string req);
    rd_chk(req, 7'h13);
    rd_chk(req, 7'h45);
    rd_chk(req, 7'h46);
  endtask

  initial begin
    logic [23:0] g;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset dout", {23'd0, dout}, 24'd0);
    rw_all("R11 reset value");

    wr(7'h13, 24'hA5);
    rd_chk("R4 mode write/read", 7'h13);
    wr(7'h45, 24'h1234);
    rd_chk("R4 R2 numerator 16-bit", 7'h45);
    wr(7'h46, 24'hFFFF);
    rd_chk("R5 denominator masked", 7'h46);
    chk("R5 pad value", 24'(den_m), 24'h000FFF);

    freq_in = 12'hABC; temp_in = 8'h5A;
    rd_chk("R2 R5 frequency two bytes", 7'h10);
    rd_chk("R2 temperature one byte", 7'h11);
    wave_in = 16'h8001;
    rd_chk("R8 negative sample", 7'h12);
    wave_in = 16'h7FFE;
    rd_chk("R8 positive sample", 7'h12);

    // R1: read frame at a writable address with ones on din changes nothing
    xfer(8'h13, 24'hFF, 8, g);
    chk("R1 R3 read frame data", g, 24'h0000A5);
    rd_chk("R1 read frame no write", 7'h13);

    // R6: writes to read-only addresses are dropped
    begin
      logic [23:0] g2;
      xfer({1'b1, 7'h11}, 24'hFF, 8, g2);
      xfer({1'b1, 7'h10}, 24'hFFFF, 16, g2);
    end
    rd_chk("R6 temperature still input", 7'h11);
    rw_all("R6 bank unchanged");

    // R7: reserved window
    xfer({1'b1, 7'h50}, 24'h3C, 8, g);
    xfer({1'b1, 7'h49}, 24'hC3, 8, g);
    rw_all("R7 reserved write dropped");
    rd_chk("R7 reserved low edge", 7'h49);
    rd_chk("R7 reserved high edge", 7'h7D);
    rd_chk("R7 reserved mid", 7'h60);

    // R9: aborted writes
    xfer({1'b1, 7'h13}, 24'h0F, 4, g);
    rd_chk("R9 abort mid byte", 7'h13);
    xfer({1'b1, 7'h45}, 24'h00BE, 8, g);
    rd_chk("R9 abort after one byte", 7'h45);

    // R12: extra bits after a complete write are ignored
    xfer({1'b1, 7'h13}, 24'h3CFF, 16, g);
    mode_m = 'h3C;
    rd_chk("R12 trailing bits ignored", 7'h13);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule